// File: doc/BRIEF.md
# Preloadable Down-Counting Wake Timer

This block is one timer channel that counts down from a starting value and then restarts. Each count event comes from one of three places: the system clock (one event per cycle), single-cycle tick pulses from an external prescaler, or rising edges on an external input pin. When the count reaches zero the channel sets a sticky overflow flag and emits a one-cycle wake pulse. On the next event it reloads from its preload register.

Software can load the active count directly while the channel is disabled. The channel then counts from that value down to zero before it first reloads from the preload register. A low-power stop input freezes every source except the prescaler ticks. This lets a prescaler-clocked channel wake the system after a set delay. The wake pulse does not depend on the interrupt enable. The interrupt output is the sticky flag gated by that enable.

Top module: `wake_timer`

## Requirements
- R1: With the channel disabled, or with source code 01 (none) selected, no count event occurs. The count changes only through register writes.
- R2: While enabled, each selected event lowers the count by one while it is nonzero.
- R3: The event that takes the count to zero sets the flag and pulses the wake output in the following cycle. The next event loads the count from the preload register.
- R4: A count write while disabled replaces the count. After enabling, the channel counts that value down to zero before it reloads. A preload write made after the count write only changes the reload value.
- R5: A preload write while disabled also copies the value into the count, unless a count write has happened since the channel was last enabled.
- R6: The two-bit source codes are: 00 prescaler tick, 01 none, 10 system clock (every cycle), 11 external pin rising edge.
- R7: A rising edge on the external pin is counted after a two-stage synchronizer. A pin that goes high before clock edge k is counted at edge k+2.
- R8: While the stop input is high, only the prescaler source (00) produces events. The system-clock and pin sources are frozen.
- R9: The wake output is high for exactly one cycle per zero hit, whatever the interrupt enable is.
- R10: The flag is sticky until a clear strobe. A new hit in the same cycle as a clear wins. The interrupt output equals the flag gated by the interrupt enable, registered one cycle.
- R11: With a preload of zero and a count of zero, every event is a zero hit.
- R12: A count write while enabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Channel enable |
| src_sel | input | 2 | Event source code (see R6) |
| irq_en | input | 1 | Overflow interrupt enable |
| stop_mode | input | 1 | Low-power stop indication |
| ext_pin | input | 1 | Asynchronous external event pin |
| presc_tick | input | 1 | Prescaler tick, one cycle wide |
| pre_we | input | 1 | Preload register write strobe |
| pre_wdata | input | CNT_W | Preload write data |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | CNT_W | Count write data |
| irq_clr | input | 1 | Write-one-to-clear strobe for the flag |
| count_o | output | CNT_W | Current count value |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Gated overflow interrupt |
| wake_o | output | 1 | One-cycle wake pulse at zero |

## Verification
The bench goes after the ordering of count and preload writes while the channel is disabled. A design that let a later preload write overwrite a direct count write would start counting from the wrong value. Stop mode is run with each of the three sources: a design that gated the wrong sources would either drift in stop or fail to wake. Other cases:
- The interrupt enable is held low across hits. A design that tied wake to the enable would never pulse.
- A zero preload is run. A design that was off by one here would skip hits.
- Clear strobes coincide with hits. This exposes a design where the clear wins over a new hit.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    SRC_PRESC = 2'b00,
    SRC_NONE  = 2'b01,
    SRC_SYS   = 2'b10,
    SRC_PIN   = 2'b11
  } src_e;
endpackage

// File: rtl/wt_event_sel.sv
module wt_event_sel
  import wt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [1:0] src_i,
  input  logic       stop_i,
  input  logic       pin_i,
  input  logic       presc_i,
  output logic       ev_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;
  logic         pin_rise;
  logic         tick;
  src_e         src;

  assign src = src_e'(src_i);

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[MSB-1:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[MSB];
  end

  assign pin_rise = sync_q[MSB] & ~last_q;

  always_comb begin
    unique case (src)
      SRC_PRESC: tick = presc_i;
      SRC_SYS:   tick = 1'b1;
      SRC_PIN:   tick = pin_rise;
      default:   tick = 1'b0;
    endcase
  end

  assign ev_o = en_i & tick & (~stop_i | (src == SRC_PRESC));

  // R8: stop freezes every source but the prescaler
  a_r8_stop_gate: assert property (@(posedge clk) disable iff (rst)
    (stop_i && src_i != 2'b00) |-> !ev_o);
  // R1: disabled or source "none" gives no events
  a_r1_no_event: assert property (@(posedge clk) disable iff (rst)
    (!en_i || src_i == 2'b01) |-> !ev_o);
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             ev_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             pre_we_i,
  input  logic [CNT_W-1:0] pre_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pre_q;
  logic             direct_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= ZERO;
      pre_q    <= ZERO;
      direct_q <= 1'b0;
    end else begin
      if (pre_we_i) pre_q <= pre_wdata_i;
      if (en_i) direct_q <= 1'b0;
      if (ev_i) begin
        cnt_q <= (cnt_q == ZERO) ? pre_q : cnt_q - ONE;
      end else if (!en_i) begin
        if (cnt_we_i) begin
          cnt_q    <= cnt_wdata_i;
          direct_q <= 1'b1;
        end else if (pre_we_i && !direct_q) begin
          cnt_q <= pre_wdata_i;
        end
      end
    end
  end

  assign hit_o = ev_i & ((cnt_q == ZERO) ? (pre_q == ZERO) : (cnt_q == ONE));
  assign cnt_o = cnt_q;

  // R1: disabled with no writes keeps the count
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !cnt_we_i && !pre_we_i) |=> $stable(cnt_o));
  // R12: enabled without an event keeps the count, count writes ignored
  a_r12_no_write: assert property (@(posedge clk) disable iff (rst)
    (en_i && !ev_i) |=> $stable(cnt_o));
  // R2: a nonzero count drops by one per event
  a_r2_dec: assert property (@(posedge clk) disable iff (rst)
    (ev_i && cnt_o != ZERO) |=> (cnt_o == $past(cnt_o) - ONE));
endmodule

// File: rtl/wt_irq.sv
module wt_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o
);
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (clr_i) flag_d = 1'b0;
    if (hit_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      flag_o <= flag_d;
      irq_o  <= flag_d & irq_en_i;
      wake_o <= hit_i;
    end
  end

  // R3/R10: a hit always leaves the flag set and pulses wake
  a_r3_hit_sets: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> (flag_o && wake_o));
  // R9: wake never occurs without the flag
  a_r9_wake_flag: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> flag_o);
  // R10: interrupt only when the enable was high
  a_r10_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en_i));
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic [1:0]       src_sel,
  input  logic             irq_en,
  input  logic             stop_mode,
  input  logic             ext_pin,
  input  logic             presc_tick,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic ev;
  logic hit;

  wt_event_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst(rst), .en_i(tmr_en), .src_i(src_sel), .stop_i(stop_mode),
    .pin_i(ext_pin), .presc_i(presc_tick), .ev_o(ev)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(tmr_en), .ev_i(ev),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .pre_we_i(pre_we), .pre_wdata_i(pre_wdata),
    .cnt_o(count_o), .hit_o(hit)
  );

  wt_irq u_irq (
    .clk(clk), .rst(rst), .hit_i(hit), .irq_en_i(irq_en), .clr_i(irq_clr),
    .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );
endmodule

// File: tb/wake_timer_bench.sv
`timescale 1ns/100ps
module wake_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_en = 1'b0;
  logic [1:0]  src_sel = 2'b01;
  logic        irq_en = 1'b0;
  logic        stop_mode = 1'b0;
  logic        ext_pin = 1'b0;
  logic        presc_tick = 1'b0;
  logic        pre_we = 1'b0;
  logic [15:0] pre_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        irq_clr = 1'b0;
  logic [15:0] count_o;
  logic        flag_o, irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  string ph = "R1";

  always #2.5 clk = ~clk;

  wake_timer u_wake_timer (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .src_sel(src_sel), .irq_en(irq_en),
    .stop_mode(stop_mode), .ext_pin(ext_pin), .presc_tick(presc_tick),
    .pre_we(pre_we), .pre_wdata(pre_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .irq_clr(irq_clr), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // behavioural reference model
  int m_cnt, m_pre, m_flag, m_irq, m_wake, m_direct;
  int m_sync[2];
  int m_last;

  always @(posedge clk) begin
    int rise, tk, ev, hit;
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_flag = 0; m_irq = 0; m_wake = 0; m_direct = 0;
      m_sync[0] = 0; m_sync[1] = 0; m_last = 0;
    end else begin
      rise = (m_sync[1] == 1 && m_last == 0) ? 1 : 0;
      case (src_sel)
        2'b00:   tk = presc_tick;
        2'b10:   tk = 1;
        2'b11:   tk = rise;
        default: tk = 0;
      endcase
      ev  = (tmr_en && tk && (!stop_mode || src_sel == 2'b00)) ? 1 : 0;
      hit = (ev && ((m_cnt == 0) ? (m_pre == 0) : (m_cnt == 1))) ? 1 : 0;
      m_wake = hit;
      if (irq_clr) m_flag = 0;
      if (hit) m_flag = 1;
      m_irq = (m_flag && irq_en) ? 1 : 0;
      if (ev) m_cnt = (m_cnt == 0) ? m_pre : m_cnt - 1;
      else if (!tmr_en) begin
        if (cnt_we) begin m_cnt = cnt_wdata; m_direct = 1; end
        else if (pre_we && !m_direct) m_cnt = pre_wdata;
      end
      if (tmr_en) m_direct = 0;
      if (pre_we) m_pre = pre_wdata;
      m_last = m_sync[1];
      m_sync[1] = m_sync[0];
      m_sync[0] = ext_pin;
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #1.5;
    cycles++;
    if (!rst) begin
      chk({ph, " count"}, count_o, m_cnt);
      chk({ph, " flag"},  flag_o,  m_flag);
      chk({ph, " irq"},   irq_o,   m_irq);
      chk({ph, " wake"},  wake_o,  m_wake);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pre(int v);
    pre_we = 1'b1; pre_wdata = v[15:0];
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic wr_cnt(int v);
    cnt_we = 1'b1; cnt_wdata = v[15:0];
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic presc_run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      presc_tick = 1'b1; @(negedge clk);
      presc_tick = 1'b0; step(gap);
    end
  endtask

  task automatic pin_run(int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; step(2);
      ext_pin = 1'b0; step(3);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    n_fail++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    ph = "R1 reset";
    chk("R1 reset count", count_o, 0);
    chk("R1 reset flag", flag_o, 0);
    chk("R1 reset wake", wake_o, 0);
    // R1: disabled, source none, noise everywhere
    ph = "R1";
    src_sel = 2'b01;
    presc_run(4, 1);
    pin_run(3);
    chk("R1 idle count", count_o, 0);
    // R5: preload write while disabled copies into count
    ph = "R5";
    wr_pre(5);
    chk("R5 count from preload", count_o, 5);
    // R4: count write wins, later preload only affects reload
    ph = "R4";
    wr_cnt(3);
    wr_pre(7);
    chk("R4 count kept", count_o, 3);
    src_sel = 2'b10; tmr_en = 1'b1; irq_en = 1'b1;
    step(12);
    // R3 / R6 system source, reload run
    ph = "R3";
    step(10);
    tmr_en = 1'b0;
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    // R9: wake without interrupt enable
    ph = "R9";
    irq_en = 1'b0;
    wr_pre(2);
    wr_cnt(2);
    tmr_en = 1'b1;
    step(9);
    // R10: enable raises interrupt from sticky flag, clears vs hits
    ph = "R10";
    irq_en = 1'b1;
    step(2);
    for (int i = 0; i < 8; i++) begin
      irq_clr = 1'b1; step(1); irq_clr = 1'b0; step(i % 3);
    end
    tmr_en = 1'b0;
    // R8 / R6: stop mode with the prescaler source still counts
    ph = "R8";
    wr_pre(20);
    tmr_en = 1'b1; src_sel = 2'b00; stop_mode = 1'b1;
    presc_run(6, 2);
    src_sel = 2'b10; step(8);
    src_sel = 2'b11; pin_run(3);
    src_sel = 2'b01; presc_run(3, 1);
    // R7: pin edges after synchronizer
    ph = "R7";
    stop_mode = 1'b0; src_sel = 2'b11;
    pin_run(6);
    // R2: prescaler decrement pattern
    ph = "R2";
    src_sel = 2'b00;
    presc_run(10, 0);
    presc_run(6, 3);
    // R12: count write while enabled ignored
    ph = "R12";
    wr_cnt(1234);
    step(2);
    tmr_en = 1'b0;
    // R11: zero preload gives a hit on every event
    ph = "R11";
    wr_pre(0);
    wr_cnt(0);
    src_sel = 2'b10; tmr_en = 1'b1;
    step(6);
    src_sel = 2'b00; presc_run(4, 1);
    tmr_en = 1'b0;
    step(3);
    finish_run();
  end
endmodule